// File: doc/BRIEF.md
# Serial PHY Management Bus Master

This block is a master for the two-wire PHY management bus. It generates the management clock (MDC) from the system clock and drives or releases the shared data line (MDIO). It uses three separate signals for the data line: a value to drive, an output enable and an input. Each command carries a start strike, a read/write flag, an addressing-mode flag, a 5-bit PHY address, a 21-bit register address and 16 bits of write data. The block then runs one complete register access on the bus and signals the end of it with a single-cycle done pulse. For reads it also returns the captured data and a turnaround-error flag.

In short-frame mode one frame carries the whole access. In extended-address mode the block sends two frames back to back and needs no outside help. The first frame sets the 16-bit register offset inside the selected device. The line is then released for one extra clock. The second frame performs the read or the write on the device named by address bits 20:16.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 clock periods in which the master drives MDIO to 1.
- R2: A short-frame access (cmd_ext = 0) sends, most significant bit first, start code 01, opcode 10 for read or 01 for write, the 5-bit PHY address, then cmd_reg[4:0]; bits 20:5 of cmd_reg have no effect on the bus.
- R3: In a write frame the master drives turnaround bits 1 then 0, followed by the 16 data bits most significant bit first.
- R4: In a read frame the master releases MDIO (oe = 0) for all 18 bit periods after the register field, and it assembles rsp_rdata from the last 16 of them, most significant bit first, sampled at MDC rising edges.
- R5: An extended access (cmd_ext = 1) sends first a frame with start 00, opcode 00, the PHY address, cmd_reg[20:16], turnaround 10 and cmd_reg[15:0]. One released, clocked bit period follows. The second frame then has start 00, opcode 11 (read) or 01 (write), the same PHY and device fields, and the read or write body of R3/R4.
- R6: MDC stays low for exactly DIV_HALF system clocks per bit and high for at least DIV_HALF. MDC rests high when no access runs. Driven data changes only while MDC is low.
- R7: On a read, if the second turnaround bit is sampled as 1, rsp_ta_err is 1 and rsp_rdata is 16'hFFFF. Otherwise rsp_ta_err is 0. After a write, rsp_ta_err is 0.
- R8: rsp_done is high for exactly one system clock after the last bit of the whole access. By then, 64 MDC rising edges have been produced for a short access and 129 for an extended one.
- R9: A cmd_start raised while an access is in progress is ignored. It adds no bits, no frame and no done pulse.
- R10: After reset, MDC is 1, mdio_oe is 0, rsp_done is 0, rsp_ta_err is 0 and rsp_rdata is 0.
- R11: Whenever no access is in progress the master leaves MDIO released (mdio_oe = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start strike, taken only when idle |
| cmd_read | input | 1 | 1 = read access, 0 = write access |
| cmd_ext | input | 1 | 1 = extended two-frame addressing, 0 = short frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 21 | Register address: device in 20:16 and offset in 15:0 (extended), or register in 4:0 (short) |
| cmd_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| rsp_ta_err | output | 1 | Turnaround error of the last access, valid with rsp_done |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | Drive enable for MDIO |
| mdio_i | input | 1 | Sampled MDIO level |

## Verification
The bench builds the block with DIV_HALF = 2, so one bit period is four system clocks. At that speed an extended access takes a little over 500 cycles, which leaves room to sweep all 32 PHY addresses in both modes, for both reads and writes, with register, device and data fields that change on every step. A bench-side PHY model answers reads, or stays silent to force turnaround errors. Every recorded bit, with its drive enable, is compared with a frame built arithmetically from the command.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int PHY_W      = 5;
    localparam int DEV_W      = 5;
    localparam int DATA_W     = 16;
    localparam int REG_AW     = DEV_W + DATA_W;
    localparam int HDR_BITS   = PRE_BITS + 2 + 2 + PHY_W + DEV_W;
    localparam int FRAME_BITS = HDR_BITS + 2 + DATA_W;
    localparam int RX_BITS    = DATA_W + 1;
    localparam int BIT_CW     = $clog2(FRAME_BITS + 2);

    localparam logic [1:0] START_SHORT = 2'b01;
    localparam logic [1:0] START_EXT   = 2'b00;
    localparam logic [1:0] OPS_READ    = 2'b10;
    localparam logic [1:0] OPS_WRITE   = 2'b01;
    localparam logic [1:0] OPX_ADDR    = 2'b00;
    localparam logic [1:0] OPX_READ    = 2'b11;
    localparam logic [1:0] OPX_WRITE   = 2'b01;
    localparam logic [1:0] TA_DRIVEN   = 2'b10;

    typedef enum logic [1:0] {E_IDLE, E_RUN, E_TAIL} eng_st_e;
    typedef enum logic [1:0] {Q_IDLE, Q_ADR, Q_XFR} seq_st_e;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic [1:0]        st,
        input logic [1:0]        op,
        input logic [PHY_W-1:0]  phy,
        input logic [DEV_W-1:0]  rf,
        input logic [DATA_W-1:0] body
    );
        return {{PRE_BITS{1'b1}}, st, op, phy, rf, TA_DRIVEN, body};
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic freeze,
    output logic mdc,
    output logic tick,
    output logic fall_stb,
    output logic rise_stb
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(DIV_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t q, n;

    always_comb begin
        n    = q;
        tick = run && (q.cnt == CNT_TOP);
        if (!run) begin
            n.cnt = '0;
            n.mdc = 1'b1;
        end else begin
            n.cnt = tick ? '0 : q.cnt + 1'b1;
            if (tick && !freeze) begin
                n.mdc = ~q.mdc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cnt: '0, mdc: 1'b1};
        end else begin
            q <= n;
        end
    end

    assign mdc      = q.mdc;
    assign fall_stb = tick && !freeze && q.mdc;
    assign rise_stb = tick && !freeze && !q.mdc;

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  launch,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  drive_all,
    input  logic                  extra,
    input  logic                  mdio_i,
    input  logic                  tick,
    input  logic                  fall_stb,
    input  logic                  rise_stb,
    output logic                  run,
    output logic                  freeze,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  frame_done,
    output logic [RX_BITS-1:0]    rx
);
    localparam logic [BIT_CW-1:0] HDR_IDX = BIT_CW'(HDR_BITS);
    localparam logic [BIT_CW-1:0] FRM_IDX = BIT_CW'(FRAME_BITS);
    localparam logic [BIT_CW-1:0] LAST_N  = BIT_CW'(FRAME_BITS - 1);
    localparam logic [BIT_CW-1:0] LAST_X  = BIT_CW'(FRAME_BITS);

    typedef struct packed {
        eng_st_e               st;
        logic [FRAME_BITS-1:0] sh;
        logic [BIT_CW-1:0]     bitn;
        logic [BIT_CW-1:0]     last;
        logic                  drv;
        logic [RX_BITS-1:0]    rx;
        logic                  o;
        logic                  oe;
        logic                  done;
    } eng_t;

    eng_t q, n;
    logic drive_now;

    always_comb begin
        n         = q;
        n.done    = 1'b0;
        drive_now = 1'b0;
        unique case (q.st)
            E_IDLE: begin
                if (launch) begin
                    n.st   = E_RUN;
                    n.sh   = frame;
                    n.bitn = '0;
                    n.last = extra ? LAST_X : LAST_N;
                    n.drv  = drive_all;
                    n.rx   = '0;
                end
            end
            E_RUN: begin
                if (fall_stb) begin
                    drive_now = (q.bitn < HDR_IDX) || (q.drv && (q.bitn < FRM_IDX));
                    n.oe      = drive_now;
                    n.o       = drive_now ? q.sh[FRAME_BITS-1] : 1'b1;
                    n.sh      = {q.sh[FRAME_BITS-2:0], 1'b0};
                end
                if (rise_stb) begin
                    if ((q.bitn > HDR_IDX) && (q.bitn < FRM_IDX)) begin
                        n.rx = {q.rx[RX_BITS-2:0], mdio_i};
                    end
                    if (q.bitn == q.last) begin
                        n.st = E_TAIL;
                    end else begin
                        n.bitn = q.bitn + 1'b1;
                    end
                end
            end
            E_TAIL: begin
                if (tick) begin
                    n.st   = E_IDLE;
                    n.oe   = 1'b0;
                    n.o    = 1'b1;
                    n.done = 1'b1;
                end
            end
            default: n.st = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: E_IDLE, sh: '0, bitn: '0, last: '0, drv: 1'b0,
                   rx: '0, o: 1'b1, oe: 1'b0, done: 1'b0};
        end else begin
            q <= n;
        end
    end

    assign run        = (q.st != E_IDLE);
    assign freeze     = (q.st == E_TAIL);
    assign mdio_o     = q.o;
    assign mdio_oe    = q.oe;
    assign frame_done = q.done;
    assign rx         = q.rx;

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  is_rd,
    input  logic                  is_ext,
    input  logic [PHY_W-1:0]      phy,
    input  logic [REG_AW-1:0]     regaddr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  frame_done,
    input  logic [RX_BITS-1:0]    rx,
    output logic                  launch,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  drive_all,
    output logic                  extra,
    output logic [DATA_W-1:0]     rdata,
    output logic                  ta_err,
    output logic                  done,
    output logic                  busy
);
    typedef struct packed {
        seq_st_e               st;
        logic                  rd;
        logic [PHY_W-1:0]      phy;
        logic [DEV_W-1:0]      dev;
        logic [DATA_W-1:0]     wd;
        logic                  launch;
        logic [FRAME_BITS-1:0] frame;
        logic                  drv;
        logic                  extra;
        logic [DATA_W-1:0]     rdata;
        logic                  err;
        logic                  done;
    } seq_t;

    seq_t q, n;

    always_comb begin
        n        = q;
        n.launch = 1'b0;
        n.done   = 1'b0;
        unique case (q.st)
            Q_IDLE: begin
                if (start) begin
                    n.rd     = is_rd;
                    n.phy    = phy;
                    n.dev    = regaddr[REG_AW-1:DATA_W];
                    n.wd     = wdata;
                    n.launch = 1'b1;
                    if (is_ext) begin
                        n.frame = build_frame(START_EXT, OPX_ADDR, phy,
                                              regaddr[REG_AW-1:DATA_W],
                                              regaddr[DATA_W-1:0]);
                        n.drv   = 1'b1;
                        n.extra = 1'b1;
                        n.st    = Q_ADR;
                    end else begin
                        n.frame = build_frame(START_SHORT,
                                              is_rd ? OPS_READ : OPS_WRITE, phy,
                                              regaddr[DEV_W-1:0], wdata);
                        n.drv   = !is_rd;
                        n.extra = 1'b0;
                        n.st    = Q_XFR;
                    end
                end
            end
            Q_ADR: begin
                if (frame_done) begin
                    n.frame  = build_frame(START_EXT,
                                           q.rd ? OPX_READ : OPX_WRITE,
                                           q.phy, q.dev, q.wd);
                    n.drv    = !q.rd;
                    n.extra  = 1'b0;
                    n.launch = 1'b1;
                    n.st     = Q_XFR;
                end
            end
            Q_XFR: begin
                if (frame_done) begin
                    n.done = 1'b1;
                    n.st   = Q_IDLE;
                    if (q.rd) begin
                        n.err   = rx[RX_BITS-1];
                        n.rdata = rx[RX_BITS-1] ? {DATA_W{1'b1}} : rx[DATA_W-1:0];
                    end else begin
                        n.err = 1'b0;
                    end
                end
            end
            default: n.st = Q_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: Q_IDLE, rd: 1'b0, phy: '0, dev: '0, wd: '0,
                   launch: 1'b0, frame: '0, drv: 1'b0, extra: 1'b0,
                   rdata: '0, err: 1'b0, done: 1'b0};
        end else begin
            q <= n;
        end
    end

    assign launch    = q.launch;
    assign frame     = q.frame;
    assign drive_all = q.drv;
    assign extra     = q.extra;
    assign rdata     = q.rdata;
    assign ta_err    = q.err;
    assign done      = q.done;
    assign busy      = (q.st != Q_IDLE);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_read,
    input  logic              cmd_ext,
    input  logic [4:0]        cmd_phy,
    input  logic [20:0]       cmd_reg,
    input  logic [15:0]       cmd_wdata,
    output logic [15:0]       rsp_rdata,
    output logic              rsp_ta_err,
    output logic              rsp_done,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic                  seq_busy;
    logic                  eng_launch;
    logic [FRAME_BITS-1:0] eng_frame;
    logic                  eng_drive_all;
    logic                  eng_extra;
    logic                  eng_done;
    logic [RX_BITS-1:0]    eng_rx;
    logic                  div_run;
    logic                  div_freeze;
    logic                  div_tick;
    logic                  div_fall;
    logic                  div_rise;

    mdio_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cmd_start),
        .is_rd      (cmd_read),
        .is_ext     (cmd_ext),
        .phy        (cmd_phy),
        .regaddr    (cmd_reg),
        .wdata      (cmd_wdata),
        .frame_done (eng_done),
        .rx         (eng_rx),
        .launch     (eng_launch),
        .frame      (eng_frame),
        .drive_all  (eng_drive_all),
        .extra      (eng_extra),
        .rdata      (rsp_rdata),
        .ta_err     (rsp_ta_err),
        .done       (rsp_done),
        .busy       (seq_busy)
    );

    mdio_frame_eng u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (eng_launch),
        .frame      (eng_frame),
        .drive_all  (eng_drive_all),
        .extra      (eng_extra),
        .mdio_i     (mdio_i),
        .tick       (div_tick),
        .fall_stb   (div_fall),
        .rise_stb   (div_rise),
        .run        (div_run),
        .freeze     (div_freeze),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .frame_done (eng_done),
        .rx         (eng_rx)
    );

    mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (div_run),
        .freeze   (div_freeze),
        .mdc      (mdc),
        .tick     (div_tick),
        .fall_stb (div_fall),
        .rise_stb (div_rise)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_start,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        rsp_done,
    input logic        rsp_ta_err,
    input logic [15:0] rsp_rdata,
    input logic        busy
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R8

    AST_DONE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> mdc); // R6

    AST_IDLE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> mdc); // R6

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe); // R11

    AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> !mdc); // R6

    AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_ta_err) |-> (rsp_rdata == 16'hFFFF)); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start) |=> (busy || rsp_done)); // R9

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start) |=> busy); // R8

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .rsp_done   (rsp_done),
    .rsp_ta_err (rsp_ta_err),
    .rsp_rdata  (rsp_rdata),
    .busy       (seq_busy)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
    localparam int CLK_P = 10;
    localparam int DIV   = 2;
    localparam int RING  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_read = 1'b0;
    logic        cmd_ext = 1'b0;
    logic [4:0]  cmd_phy = '0;
    logic [20:0] cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] rsp_rdata;
    logic        rsp_ta_err;
    logic        rsp_done;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;
    bit fin = 1'b0;

    logic rec_oe [RING];
    logic rec_v  [RING];
    int   rec_n = 0;
    logic mdc_prev = 1'b1;
    int   run_len = 0;
    int   per_bad = 0;
    int   per_seen = 0;
    int   done_cnt = 0;

    int          base = 0;
    bit          resp_on = 1'b0;
    int          resp_off = 0;
    logic [15:0] resp_data = '0;

    logic exp_oe [0:159];
    logic exp_v  [0:159];
    int   exp_n = 0;

    always #(CLK_P/2) clk = ~clk;

    mdio_master #(.DIV_HALF(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_read(cmd_read),
        .cmd_ext(cmd_ext), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
        .cmd_wdata(cmd_wdata), .rsp_rdata(rsp_rdata), .rsp_ta_err(rsp_ta_err),
        .rsp_done(rsp_done), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    // PHY side model: bit at index rel of the access, as the PHY drives it
    function automatic logic phy_bit(input int rel);
        int p;
        p = rel - resp_off;
        if (!resp_on || p < 0) return 1'b1;
        if (p == 47) return 1'b0;
        if (p >= 48 && p <= 63) return resp_data[63 - p];
        return 1'b1;
    endfunction

    always @(negedge clk) begin
        if (mdc !== mdc_prev && mdc !== 1'bx) begin
            per_seen <= per_seen + 1;
            if (mdc && run_len != DIV) per_bad <= per_bad + 1;
            if (!mdc && run_len < DIV) per_bad <= per_bad + 1;
            run_len <= 1;
        end else begin
            run_len <= run_len + 1;
        end
        if (mdc === 1'b1 && mdc_prev === 1'b0) begin
            rec_oe[rec_n % RING] <= mdio_oe;
            rec_v[rec_n % RING]  <= mdio_o;
            rec_n <= rec_n + 1;
        end
        if (mdc === 1'b0 && mdc_prev === 1'b1) begin
            mdio_i <= phy_bit(rec_n - base);
        end
        if (rsp_done === 1'b1) done_cnt <= done_cnt + 1;
        mdc_prev <= mdc;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [63:0] mkf(input logic [1:0] st, input logic [1:0] op,
                                        input logic [4:0] phy, input logic [4:0] rf,
                                        input logic [15:0] body);
        return {32'hFFFF_FFFF, st, op, phy, rf, 2'b10, body};
    endfunction

    task automatic put_frame(input int off, input logic [63:0] f, input bit drv);
        for (int i = 0; i < 64; i++) begin
            exp_oe[off + i] = (i < 46) || drv;
            exp_v[off + i]  = f[63 - i];
        end
    endtask

    task automatic cmp_stream(input string req);
        int first_bad;
        int pre_bad;
        first_bad = -1;
        pre_bad = 0;
        for (int i = 0; i < exp_n; i++) begin
            int k;
            k = (base + i) % RING;
            if (rec_oe[k] !== exp_oe[i] || (exp_oe[i] && rec_v[k] !== exp_v[i])) begin
                if (i < 32 || (i >= 65 && i < 97)) pre_bad++;
                else if (first_bad < 0) first_bad = i;
            end
        end
        chk(pre_bad == 0, "R1 preamble", pre_bad, 0);
        chk(first_bad < 0, req, first_bad, -1);
    endtask

    task automatic xact(input bit ext, input bit rd, input logic [4:0] phy,
                        input logic [20:0] ra, input logic [15:0] wd,
                        input bit respond, input logic [15:0] pd, input string req);
        int n;
        base      = rec_n;
        resp_on   = rd && respond;
        resp_off  = ext ? 65 : 0;
        resp_data = pd;
        if (ext) begin
            put_frame(0, mkf(2'b00, 2'b00, phy, ra[20:16], ra[15:0]), 1'b1);
            exp_oe[64] = 1'b0;
            exp_v[64]  = 1'b1;
            put_frame(65, mkf(2'b00, rd ? 2'b11 : 2'b01, phy, ra[20:16], wd), !rd);
            exp_n = 129;
        end else begin
            put_frame(0, mkf(2'b01, rd ? 2'b10 : 2'b01, phy, ra[4:0], wd), !rd);
            exp_n = 64;
        end
        @(negedge clk);
        cmd_ext = ext; cmd_read = rd; cmd_phy = phy; cmd_reg = ra; cmd_wdata = wd;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        n = 0;
        while (rsp_done !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(rsp_done === 1'b1, "R8 done seen", rsp_done, 1);
        if (rd) begin
            chk(rsp_ta_err === !respond, "R7 ta_err", rsp_ta_err, !respond);
            chk(rsp_rdata === (respond ? pd : 16'hFFFF), "R4/R7 rdata",
                rsp_rdata, respond ? pd : 16'hFFFF);
        end else begin
            chk(rsp_ta_err === 1'b0, "R7 write clears", rsp_ta_err, 0);
        end
        chk(mdio_oe === 1'b0, "R11 released", mdio_oe, 0);
        chk(rec_n - base == exp_n, "R8 bit count", rec_n - base, exp_n);
        cmp_stream(req);
        @(negedge clk);
        chk(rsp_done === 1'b0, "R8 done single", rsp_done, 0);
        chk(mdc === 1'b1, "R6 idle high", mdc, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mdc === 1'b1, "R10 mdc", mdc, 1);
        chk(mdio_oe === 1'b0, "R10 oe", mdio_oe, 0);
        chk(rsp_done === 1'b0, "R10 done", rsp_done, 0);
        chk(rsp_ta_err === 1'b0, "R10 err", rsp_ta_err, 0);
        chk(rsp_rdata === 16'h0, "R10 rdata", rsp_rdata, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(mdio_oe === 1'b0, "R11 idle", mdio_oe, 0);

        for (int p = 0; p < 32; p++) begin
            logic [4:0]  phy;
            logic [20:0] ra;
            logic [15:0] wd;
            phy = 5'(p);
            ra  = {~phy, 16'(p * 16'h0841) ^ 16'hA5C3};
            wd  = 16'(p * 16'h1111) ^ 16'h5A0F;
            xact(1'b0, 1'b0, phy, ra, wd, 1'b1, 16'h0, "R2/R3 short write");
            xact(1'b0, 1'b1, phy, ra, wd, 1'b1, ~wd, "R2/R4 short read");
            xact(1'b1, 1'b0, phy, ra, wd, 1'b1, 16'h0, "R5/R3 ext write");
            xact(1'b1, 1'b1, phy, ra, wd, 1'b1, wd ^ 16'h8001, "R5/R4 ext read");
        end

        xact(1'b0, 1'b1, 5'd31, 21'h1FFFFF, 16'h0, 1'b1, 16'h0000, "R4 zero data");
        xact(1'b0, 1'b1, 5'd7, 21'h00003, 16'h0, 1'b0, 16'h0, "R7 short no reply");
        xact(1'b1, 1'b1, 5'd12, 21'h0ABCD, 16'h0, 1'b0, 16'h0, "R7 ext no reply");
        xact(1'b1, 1'b0, 5'd31, 21'h1FFFFF, 16'hFFFF, 1'b1, 16'h0, "R5 all ones");

        // R9: second start during a running access
        begin
            int d0;
            int n;
            d0 = done_cnt;
            base = rec_n;
            resp_on = 1'b0;
            resp_off = 0;
            put_frame(0, mkf(2'b01, 2'b01, 5'd3, 5'd7, 16'h1234), 1'b1);
            exp_n = 64;
            @(negedge clk);
            cmd_ext = 1'b0; cmd_read = 1'b0; cmd_phy = 5'd3;
            cmd_reg = 21'h00007; cmd_wdata = 16'h1234; cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
            repeat (60) @(negedge clk);
            cmd_ext = 1'b1; cmd_read = 1'b1; cmd_phy = 5'd9;
            cmd_reg = 21'h1C0DE; cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
            n = 0;
            while (rsp_done !== 1'b1 && n < 5000) begin
                @(negedge clk);
                n++;
            end
            repeat (1000) @(negedge clk);
            chk(done_cnt == d0 + 1, "R9 one done", done_cnt - d0, 1);
            chk(rec_n - base == 64, "R9 no extra bits", rec_n - base, 64);
            cmp_stream("R9 first command kept");
        end

        chk(per_bad == 0 && per_seen > 0, "R6 mdc period", per_bad, 0);
        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule